// File: doc/BRIEF.md
# Stereo Serial Audio Port (two-format framing)

This block moves stereo audio between a three-wire serial link (bit clock, word clock, data) and a 40-bit parallel sample. Each sample carries two 20-bit channel lanes: left in the upper half and right in the lower half. The link side runs in one of two framings. In the first, each channel word starts one bit clock after the word-clock edge and is sent MSB first. In the second, each word is right-justified against the next word-clock edge. A word-length code picks 16, 18 or 20 bits. A further code keeps the frame timing running but sends and delivers nothing but zeros.

Everything runs on the system clock. The bit clock, the word clock and the serial input are synchronised together and examined for edges. The bit and word clocks can come from three places: the block's own pins, a divider inside the block, or a sibling port's clocks. When the divider is used, the block drives both clocks out on its pins, with the word clock derived from the bit clock. Either clock can be inverted after source selection. Once per frame, at the start of the left half, a one-cycle strobe hands over the received sample and takes in the next sample to send.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is asserted, `rx_sample` is 0 and `sdata_o`, `frame_stb`, `bclk_o` and `wclk_o` are all 0.
- R2: `cfg_frame` sets the bit clocks per word-clock half. Code 3'b100 gives 32, 3'b010 gives 24 and every other code gives 16, so frames are 64, 48 and 32 bit clocks. Bits that fall outside a half are dropped.
- R3: With `cfg_eiaj`=0, the left channel is the half where the word clock is low. Lane bit 19 is at bit position 1 after the word-clock edge, and lower bits follow at later positions. Size codes 2'b00, 2'b01 and 2'b10 behave identically and always carry the full 20-bit lane.
- R4: With `cfg_eiaj`=1, the left channel is the half where the word clock is high. The word is right-justified, so its LSB is at the last bit position of the half. `cfg_size` 2'b00/2'b01/2'b10 select W=16/18/20. The link carries lane bits 19 down to 20-W, and received lanes have zeros below bit 20-W.
- R5: With `cfg_size`=2'b11, `sdata_o` stays 0 and every published `rx_sample` is 0, while frame strobes continue once per frame.
- R6: `frame_stb` is a one-cycle pulse, issued once per frame when the left half begins. At that strobe, `rx_sample` holds the frame just completed, and `tx_sample` is taken for the frame that is starting.
- R7: `sdata_o` changes only after a falling edge of the internal bit clock. Received bits are taken on its rising edge.
- R8: `cfg_bclk_inv` and `cfg_wclk_inv` invert the selected bit clock and word clock before both the transmitter and the receiver.
- R9: With `cfg_src`=2'b01, the block generates its clocks and `clk_drive_o` is 1. `bclk_o` toggles every `cfg_div`+1 system clocks. `wclk_o` toggles on a falling edge of `bclk_o` once per half-length of bit clocks. These clocks run the port.
- R10: With `cfg_src`=2'b10, the port runs from `sib_bclk_i`/`sib_wclk_i`, ignores its own clock pins and holds `clk_drive_o` at 0. Codes 2'b00 and 2'b11 use the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Word length code, 2'b11 mutes |
| cfg_eiaj | input | 1 | 1 = right-justified framing, 0 = delayed MSB-first framing |
| cfg_frame | input | 3 | Bit clocks per frame code |
| cfg_bclk_inv | input | 1 | Invert the selected bit clock |
| cfg_wclk_inv | input | 1 | Invert the selected word clock |
| cfg_src | input | 2 | Clock source: pins, generated, sibling |
| cfg_div | input | 8 | Bit clock half-period minus one, in system clocks |
| bclk_i | input | 1 | Bit clock pin input |
| wclk_i | input | 1 | Word clock pin input |
| sib_bclk_i | input | 1 | Sibling port bit clock |
| sib_wclk_i | input | 1 | Sibling port word clock |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out |
| bclk_o | output | 1 | Generated bit clock |
| wclk_o | output | 1 | Generated word clock |
| clk_drive_o | output | 1 | High when the clock pins are driven |
| tx_sample | input | 40 | Sample to send, left in [39:20] |
| rx_sample | output | 40 | Last received sample, left in [39:20] |
| frame_stb | output | 1 | One-cycle frame strobe |

## Verification
If the bit position counter slips or the channel flag is wrong, the fault shows at the ports within one frame. The published `rx_sample` comes out shifted, with its halves swapped, or with nonzero padding bits, and the bits decoded from `sdata_o` mismatch on the next frame. A missed word-clock edge shows up as a missing or doubled `frame_stb` within one frame period. A wrong word-length or frame-length decode changes which lane bits survive, so it is visible as soon as one sample has been published. Divider errors change the measured `bclk_o` half-period and the number of bit clocks per `wclk_o` half within one half-frame.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
package asp_pkg;

  typedef enum logic [1:0] {
    SRC_PINS   = 2'd0,
    SRC_GEN    = 2'd1,
    SRC_FOLLOW = 2'd2,
    SRC_SPARE  = 2'd3
  } clk_src_e;

  localparam logic [1:0] SZ_MUTE = 2'b11;

  typedef struct packed {
    logic       ok;
    logic [7:0] idx;
  } slot_map_t;

  // bit clocks in one word-clock half
  function automatic logic [5:0] half_bits(input logic [2:0] code);
    case (code)
      3'b100:  half_bits = 6'd32;
      3'b010:  half_bits = 6'd24;
      default: half_bits = 6'd16;
    endcase
  endfunction

  // channel word length for the right-justified framing
  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'b00:   word_bits = 6'd16;
      2'b01:   word_bits = 6'd18;
      default: word_bits = 6'd20;
    endcase
  endfunction

endpackage

// File: rtl/asp_clk_gen.sv
`timescale 1ns/1ps
module asp_clk_gen #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] half,
  output logic             gen_bclk,
  output logic             gen_wclk
);

  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             bclk_q, bclk_d;
  logic             wclk_q, wclk_d;
  logic             tick, fall;

  always_comb begin
    tick   = en && (dcnt_q >= div);
    fall   = tick && bclk_q;
    dcnt_d = dcnt_q;
    bcnt_d = bcnt_q;
    bclk_d = bclk_q;
    wclk_d = wclk_q;
    if (!en) begin
      dcnt_d = '0;
      bcnt_d = '0;
      bclk_d = 1'b0;
      wclk_d = 1'b0;
    end else begin
      if (tick) begin
        dcnt_d = '0;
        bclk_d = ~bclk_q;
      end else begin
        dcnt_d = dcnt_q + 1'b1;
      end
      if (fall) begin
        if ((bcnt_q + 1'b1) >= half) begin
          bcnt_d = '0;
          wclk_d = ~wclk_q;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      bcnt_q <= '0;
      bclk_q <= 1'b0;
      wclk_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      bcnt_q <= bcnt_d;
      bclk_q <= bclk_d;
      wclk_q <= wclk_d;
    end
  end

  assign gen_bclk = bclk_q;
  assign gen_wclk = wclk_q;

  // word clock may only move together with a falling bit clock
  assert_wclk_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(wclk_q)) |-> $fell(bclk_q));

endmodule

// File: rtl/asp_clk_front.sv
`timescale 1ns/1ps
module asp_clk_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic       bclk_inv,
  input  logic       wclk_inv,
  input  logic       pin_bclk,
  input  logic       pin_wclk,
  input  logic       sib_bclk,
  input  logic       sib_wclk,
  input  logic       gen_bclk,
  input  logic       gen_wclk,
  input  logic       sdata_pin,
  output logic       bclk_rise,
  output logic       bclk_fall,
  output logic       wclk_lvl,
  output logic       sdata_lvl
);
  import asp_pkg::*;

  localparam int NSIG = 3;     // {data, word clock, bit clock}
  localparam int LAST = SYNC_STAGES - 1;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] stg_q [SYNC_STAGES];
  logic            bprev_q;
  logic            sel_b, sel_w;

  always_comb begin
    case (clk_src_e'(src))
      SRC_GEN:    begin sel_b = gen_bclk; sel_w = gen_wclk; end
      SRC_FOLLOW: begin sel_b = sib_bclk; sel_w = sib_wclk; end
      default:    begin sel_b = pin_bclk; sel_w = pin_wclk; end
    endcase
    raw = {sdata_pin, sel_w ^ wclk_inv, sel_b ^ bclk_inv};
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bprev_q <= 1'b0;
    else        bprev_q <= stg_q[LAST][0];
  end

  assign bclk_rise = stg_q[LAST][0] & ~bprev_q;
  assign bclk_fall = ~stg_q[LAST][0] & bprev_q;
  assign wclk_lvl  = stg_q[LAST][1];
  assign sdata_lvl = stg_q[LAST][2];

endmodule

// File: rtl/asp_frame_engine.sv
`timescale 1ns/1ps
module asp_frame_engine #(
  parameter int LANE_W = 20,
  parameter int POS_W  = 6,
  localparam int SMP_W = 2 * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             bclk_fall,
  input  logic             wclk_lvl,
  input  logic             sdata_lvl,
  input  logic [1:0]       cfg_size,
  input  logic             cfg_eiaj,
  input  logic [2:0]       cfg_frame,
  input  logic [SMP_W-1:0] tx_sample,
  output logic [SMP_W-1:0] rx_sample,
  output logic             frame_stb,
  output logic             sdata_o
);
  import asp_pkg::*;

  logic [POS_W-1:0] pos_q, pos_d;
  logic             ch_left_q, ch_left_d;
  logic             wc_last_q, wc_last_d;
  logic [SMP_W-1:0] tx_hold_q, tx_hold_d;
  logic [SMP_W-1:0] acc_q, acc_d;
  logic [SMP_W-1:0] rx_q, rx_d;
  logic             stb_q, stb_d;
  logic             sd_q, sd_d;

  logic             mute, new_half, left_now, start_left;
  logic [5:0]       half_len, word_len;
  logic [SMP_W-1:0] src_word, lane_sh, mask;
  logic [LANE_W-1:0] lane_word;
  slot_map_t        tx_map, rx_map;
  logic             tx_bit;

  // where a bit position of a half lands inside the 20-bit lane
  function automatic slot_map_t map_slot(input logic [POS_W-1:0] p,
                                         input logic [5:0] h,
                                         input logic [5:0] w,
                                         input logic eiaj);
    slot_map_t m;
    int pi, k;
    pi = int'(p);
    m  = '0;
    if (!eiaj) begin
      if (pi >= 1 && pi <= LANE_W) begin
        m.ok  = 1'b1;
        m.idx = 8'(LANE_W - pi);
      end
    end else begin
      k = pi - (int'(h) - int'(w));
      if (k >= 0 && k < int'(w)) begin
        m.ok  = 1'b1;
        m.idx = 8'(LANE_W - 1 - k);
      end
    end
    return m;
  endfunction

  always_comb begin
    mute       = (cfg_size == SZ_MUTE);
    half_len   = half_bits(cfg_frame);
    word_len   = word_bits(cfg_size);
    new_half   = bclk_fall && (wclk_lvl != wc_last_q);
    left_now   = cfg_eiaj ? wclk_lvl : ~wclk_lvl;
    start_left = new_half && left_now;

    wc_last_d = bclk_fall ? wclk_lvl : wc_last_q;
    if (new_half)                        pos_d = '0;
    else if (bclk_fall && pos_q != '1)   pos_d = pos_q + 1'b1;
    else                                 pos_d = pos_q;
    ch_left_d = new_half ? left_now : ch_left_q;

    // transmit side: the bit for the position that starts now
    src_word  = start_left ? tx_sample : tx_hold_q;
    lane_word = ch_left_d ? src_word[SMP_W-1:LANE_W] : src_word[LANE_W-1:0];
    tx_map    = map_slot(pos_d, half_len, word_len, cfg_eiaj);
    tx_bit    = tx_map.ok && !mute && lane_word[tx_map.idx[$clog2(LANE_W)-1:0]];
    sd_d      = bclk_fall ? tx_bit : sd_q;
    tx_hold_d = start_left ? tx_sample : tx_hold_q;

    // receive side: place the bit taken on the rising edge
    rx_map  = map_slot(pos_q, half_len, word_len, cfg_eiaj);
    lane_sh = SMP_W'(rx_map.idx) + (ch_left_q ? SMP_W'(LANE_W) : '0);
    mask    = SMP_W'(1) << lane_sh;
    acc_d   = acc_q;
    if (start_left) begin
      acc_d = '0;
    end else if (bclk_rise && rx_map.ok && !mute) begin
      acc_d = sdata_lvl ? (acc_q | mask) : (acc_q & ~mask);
    end
    rx_d  = start_left ? (mute ? '0 : acc_q) : rx_q;
    stb_d = start_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      ch_left_q <= 1'b0;
      wc_last_q <= 1'b0;
      tx_hold_q <= '0;
      acc_q     <= '0;
      rx_q      <= '0;
      stb_q     <= 1'b0;
      sd_q      <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      ch_left_q <= ch_left_d;
      wc_last_q <= wc_last_d;
      tx_hold_q <= tx_hold_d;
      acc_q     <= acc_d;
      rx_q      <= rx_d;
      stb_q     <= stb_d;
      sd_q      <= sd_d;
    end
  end

  assign rx_sample = rx_q;
  assign frame_stb = stb_q;
  assign sdata_o   = sd_q;

  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  assert_stb_in_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ch_left_q);

  assert_tx_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_fall |=> $stable(sd_q));

  assert_mute_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_fall && mute) |=> !sd_q);

  assert_mute_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && $past(mute)) |-> (rx_q == '0));

endmodule

// File: rtl/audio_serial_port.sv
`timescale 1ns/1ps
module audio_serial_port #(
  parameter int LANE_W      = 20,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 6,
  localparam int SMP_W      = 2 * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_size,
  input  logic             cfg_eiaj,
  input  logic [2:0]       cfg_frame,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_wclk_inv,
  input  logic [1:0]       cfg_src,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             bclk_i,
  input  logic             wclk_i,
  input  logic             sib_bclk_i,
  input  logic             sib_wclk_i,
  input  logic             sdata_i,
  output logic             sdata_o,
  output logic             bclk_o,
  output logic             wclk_o,
  output logic             clk_drive_o,
  input  logic [SMP_W-1:0] tx_sample,
  output logic [SMP_W-1:0] rx_sample,
  output logic             frame_stb
);
  import asp_pkg::*;

  logic gen_en, gen_bclk, gen_wclk;
  logic b_rise, b_fall, w_lvl, d_lvl;

  assign gen_en = (clk_src_e'(cfg_src) == SRC_GEN);

  asp_clk_gen #(.DIV_W(DIV_W), .CNT_W(6)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (gen_en),
    .div      (cfg_div),
    .half     (half_bits(cfg_frame)),
    .gen_bclk (gen_bclk),
    .gen_wclk (gen_wclk)
  );

  asp_clk_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (cfg_src),
    .bclk_inv  (cfg_bclk_inv),
    .wclk_inv  (cfg_wclk_inv),
    .pin_bclk  (bclk_i),
    .pin_wclk  (wclk_i),
    .sib_bclk  (sib_bclk_i),
    .sib_wclk  (sib_wclk_i),
    .gen_bclk  (gen_bclk),
    .gen_wclk  (gen_wclk),
    .sdata_pin (sdata_i),
    .bclk_rise (b_rise),
    .bclk_fall (b_fall),
    .wclk_lvl  (w_lvl),
    .sdata_lvl (d_lvl)
  );

  asp_frame_engine #(.LANE_W(LANE_W), .POS_W(POS_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_rise (b_rise),
    .bclk_fall (b_fall),
    .wclk_lvl  (w_lvl),
    .sdata_lvl (d_lvl),
    .cfg_size  (cfg_size),
    .cfg_eiaj  (cfg_eiaj),
    .cfg_frame (cfg_frame),
    .tx_sample (tx_sample),
    .rx_sample (rx_sample),
    .frame_stb (frame_stb),
    .sdata_o   (sdata_o)
  );

  assign bclk_o      = gen_bclk;
  assign wclk_o      = gen_wclk;
  assign clk_drive_o = gen_en;

  // receive edges only come from a moving bit clock
  assert_edges_need_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_rise |=> !b_rise);

endmodule

// File: tb/audio_serial_port_tb_top.sv
`timescale 1ns/1ps
module audio_serial_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_size;
  logic        cfg_eiaj;
  logic [2:0]  cfg_frame;
  logic        cfg_bclk_inv, cfg_wclk_inv;
  logic [1:0]  cfg_src;
  logic [7:0]  cfg_div;
  logic        bclk_i, wclk_i, sib_bclk_i, sib_wclk_i;
  logic        sd_drv, loop_en, sdata_in;
  logic        sdata_o, bclk_o, wclk_o, clk_drive_o;
  logic [39:0] tx_sample, rx_sample;
  logic        frame_stb;

  int total = 0;
  int bad   = 0;
  int tb_h, tb_w;
  logic tb_eiaj, tb_mute;

  int          stb_cnt = 0;
  int          stb_dbl = 0;
  logic        stb_prev = 1'b0;
  logic [39:0] rx_log [16];
  logic        bits [2][32];

  always #4 clk = ~clk;

  assign sdata_in = loop_en ? sdata_o : sd_drv;

  audio_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_eiaj(cfg_eiaj),
    .cfg_frame(cfg_frame), .cfg_bclk_inv(cfg_bclk_inv), .cfg_wclk_inv(cfg_wclk_inv),
    .cfg_src(cfg_src), .cfg_div(cfg_div), .bclk_i(bclk_i), .wclk_i(wclk_i),
    .sib_bclk_i(sib_bclk_i), .sib_wclk_i(sib_wclk_i), .sdata_i(sdata_in),
    .sdata_o(sdata_o), .bclk_o(bclk_o), .wclk_o(wclk_o), .clk_drive_o(clk_drive_o),
    .tx_sample(tx_sample), .rx_sample(rx_sample), .frame_stb(frame_stb)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_stb) begin
        rx_log[stb_cnt % 16] = rx_sample;
        stb_cnt = stb_cnt + 1;
        if (stb_prev) stb_dbl = stb_dbl + 1;
      end
      stb_prev = frame_stb;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] sz, input logic e, input logic [2:0] fr,
                         input logic bi, input logic wi, input logic [1:0] src);
    cfg_size = sz; cfg_eiaj = e; cfg_frame = fr;
    cfg_bclk_inv = bi; cfg_wclk_inv = wi; cfg_src = src;
    tb_eiaj = e; tb_mute = (sz == 2'b11);
    tb_h = (fr == 3'b100) ? 32 : (fr == 3'b010) ? 24 : 16;
    tb_w = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 18 : 20;
  endtask

  function automatic logic [19:0] keep20(input logic [19:0] v);
    logic [19:0] r = '0;
    int n;
    if (tb_mute) return '0;
    n = tb_eiaj ? tb_w : ((tb_h - 1 < 20) ? tb_h - 1 : 20);
    for (int i = 0; i < 20; i++) if (i >= 20 - n) r[i] = v[i];
    return r;
  endfunction

  function automatic logic [39:0] keep40(input logic [39:0] v);
    return {keep20(v[39:20]), keep20(v[19:0])};
  endfunction

  function automatic logic enc_bit(input logic [19:0] word, input int p);
    int k;
    if (!tb_eiaj) return (p >= 1 && p <= 20) ? word[20-p] : 1'b0;
    k = p - (tb_h - tb_w);
    return (k >= 0 && k < tb_w) ? word[19-k] : 1'b0;
  endfunction

  function automatic logic [19:0] dec_half(input int h);
    logic [19:0] r = '0;
    int p;
    if (!tb_eiaj) begin
      for (int q = 1; q <= 20; q++) if (q < tb_h) r[20-q] = bits[h][q];
    end else begin
      for (int k = 0; k < tb_w; k++) begin
        p = tb_h - tb_w + k;
        if (p >= 0) r[19-k] = bits[h][p];
      end
    end
    return r;
  endfunction

  task automatic drive_lines(input logic b, input logic w);
    logic pb, pw;
    pb = b ^ cfg_bclk_inv;
    pw = w ^ cfg_wclk_inv;
    if (cfg_src == 2'b10) begin
      sib_bclk_i = pb; sib_wclk_i = pw;
      bclk_i = ~pb;    wclk_i = ~pw;
    end else begin
      bclk_i = pb; wclk_i = pw;
    end
  endtask

  task automatic send_bit(input logic w, input logic d, input logic rec,
                          input int h, input int p, inout int ones);
    @(negedge clk);
    drive_lines(1'b0, w);
    sd_drv = d;
    repeat (8) @(negedge clk);
    drive_lines(1'b1, w);
    repeat (4) @(negedge clk);
    if (rec) begin
      bits[h][p] = sdata_o;
      if (sdata_o) ones++;
    end
    repeat (3) @(negedge clk);
  endtask

  // preamble, zero frame, frame a, frame b, then the edge that publishes b
  task automatic xfer(input logic [39:0] a, input logic [39:0] b,
                      output logic [39:0] txg, output int ones, output int c0);
    logic wl, wr;
    logic [39:0] word;
    ones = 0;
    wl = tb_eiaj ? 1'b1 : 1'b0;
    wr = ~wl;
    send_bit(wr, 1'b0, 1'b0, 0, 0, ones);
    send_bit(wr, 1'b0, 1'b0, 0, 0, ones);
    c0 = stb_cnt;
    for (int f = 0; f < 3; f++) begin
      word = (f == 0) ? 40'h0 : (f == 1) ? a : b;
      for (int h = 0; h < 2; h++)
        for (int p = 0; p < tb_h; p++)
          send_bit(h == 0 ? wl : wr, enc_bit(h == 0 ? word[39:20] : word[19:0], p),
                   f == 1, h, p, ones);
    end
    send_bit(wl, 1'b0, 1'b0, 0, 0, ones);
    repeat (8) @(negedge clk);
    txg = {dec_half(0), dec_half(1)};
  endtask

  task automatic run_port(input string req, input logic [39:0] a, input logic [39:0] b,
                          input logic [39:0] txv);
    logic [39:0] txg;
    int ones, c0;
    tx_sample = txv;
    xfer(a, b, txg, ones, c0);
    chk(req, "rx first frame", rx_log[(c0 + 2) % 16], keep40(a));
    chk(req, "rx second frame", rx_log[(c0 + 3) % 16], keep40(b));
    chk({req, " R7"}, "tx decoded", txg, keep40(txv));
    chk("R6", "strobes per run", stb_cnt - c0, 4);
  endtask

  task automatic t_reset;
    chk("R1", "rx_sample", rx_sample, 0);
    chk("R1", "out pins", {sdata_o, frame_stb, bclk_o, wclk_o}, 0);
  endtask

  task automatic t_i2s;
    set_cfg(2'b00, 1'b0, 3'b100, 1'b0, 1'b0, 2'b00);
    run_port("R3", 40'hA5C3_96E1_7B, 40'h1234_5FED_CB, 40'hF0F0_F0F0_F0);
    set_cfg(2'b10, 1'b0, 3'b100, 1'b0, 1'b0, 2'b00);
    run_port("R3", 40'hA5C3_96E1_7B, 40'h1234_5FED_CB, 40'h0F1E_2D3C_4B);
    set_cfg(2'b01, 1'b0, 3'b000, 1'b0, 1'b0, 2'b00);
    run_port("R2", 40'hFFFF_FFFF_FF, 40'h8000_1800_01, 40'hFFFF_FFFF_FF);
  endtask

  task automatic t_eiaj;
    set_cfg(2'b00, 1'b1, 3'b000, 1'b0, 1'b0, 2'b00);
    run_port("R4", 40'hFFFF_FFFF_FF, 40'h3C5A_9C3A_69, 40'hFFFF_FFFF_FF);
    set_cfg(2'b01, 1'b1, 3'b010, 1'b0, 1'b0, 2'b00);
    run_port("R4 R2", 40'hDEAD_BEEF_17, 40'h0000_3FFF_FF, 40'h5555_AAAA_33);
    set_cfg(2'b10, 1'b1, 3'b100, 1'b0, 1'b0, 2'b00);
    run_port("R4", 40'h8000_1800_01, 40'hC0FF_EE12_34, 40'h8000_1800_01);
  endtask

  task automatic t_mute;
    logic [39:0] txg;
    int ones, c0;
    set_cfg(2'b11, 1'b0, 3'b100, 1'b0, 1'b0, 2'b00);
    tx_sample = 40'hFFFF_FFFF_FF;
    xfer(40'hFFFF_FFFF_FF, 40'h1234_5678_9A, txg, ones, c0);
    chk("R5", "rx muted", rx_log[(c0 + 2) % 16], 0);
    chk("R5", "sdata_o ones", ones, 0);
    chk("R5", "strobes continue", stb_cnt - c0, 4);
  endtask

  task automatic t_invert;
    set_cfg(2'b00, 1'b1, 3'b100, 1'b1, 1'b1, 2'b00);
    run_port("R8", 40'h1357_9BDF_02, 40'hFEDC_BA98_76, 40'h2468_ACE1_35);
  endtask

  task automatic t_reserved;
    set_cfg(2'b10, 1'b0, 3'b111, 1'b0, 1'b0, 2'b00);
    run_port("R2", 40'h7777_8888_99, 40'hABCD_E012_34, 40'h9999_6666_AA);
  endtask

  task automatic t_follow;
    set_cfg(2'b00, 1'b1, 3'b010, 1'b0, 1'b0, 2'b10);
    chk("R10", "clk_drive_o", clk_drive_o, 0);
    run_port("R10", 40'h0BAD_CAFE_77, 40'h4242_4242_42, 40'h1111_EEEE_22);
  endtask

  task automatic t_generate;
    int c0, hi, falls, guard;
    logic prev_b, prev_w;
    set_cfg(2'b00, 1'b0, 3'b010, 1'b0, 1'b0, 2'b01);
    cfg_div = 8'd7;
    tx_sample = 40'hC3A5_5A3C_E1;
    loop_en = 1'b1;
    @(negedge clk);
    chk("R9", "clk_drive_o", clk_drive_o, 1);
    c0 = stb_cnt;
    guard = 0;
    while (stb_cnt < c0 + 4 && guard < 20000) begin @(negedge clk); guard++; end
    chk("R9", "loopback rx", rx_log[(stb_cnt - 1) % 16], keep40(40'hC3A5_5A3C_E1));
    // half-period of bclk_o
    while (bclk_o != 1'b0) @(negedge clk);
    while (bclk_o != 1'b1) @(negedge clk);
    hi = 0;
    while (bclk_o == 1'b1) begin hi++; @(negedge clk); end
    chk("R9", "bclk_o high cycles", hi, 8);
    // bit clocks per word clock half
    prev_w = wclk_o;
    while (wclk_o == prev_w) @(negedge clk);
    prev_w = wclk_o; prev_b = bclk_o; falls = 0;
    while (wclk_o == prev_w) begin
      @(negedge clk);
      if (prev_b && !bclk_o) falls++;
      prev_b = bclk_o;
    end
    chk("R9", "falls per half", falls, 24);
    loop_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; loop_en = 1'b0; sd_drv = 1'b0; cfg_div = 8'd3;
    bclk_i = 1'b0; wclk_i = 1'b0; sib_bclk_i = 1'b0; sib_wclk_i = 1'b0;
    tx_sample = '0;
    set_cfg(2'b00, 1'b0, 3'b100, 1'b0, 1'b0, 2'b00);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_i2s();
    t_eiaj();
    t_mute();
    t_invert();
    t_reserved();
    t_follow();
    t_generate();
    chk("R6", "double-wide strobes", stb_dbl, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule